// File: doc/BRIEF.md
# Guarded Control-Clear and Sticky Interrupt Status Unit

This unit sits beside a bank of timer channels and owns three small register functions reached through a word-wide register port. The first is a key register. A command byte taken from data bits [8:1] either opens or shuts a protection latch. The second is a clear port. Once the latch is open, writing a 1 to a bit position asks the control register to drop that bit. The unit does not hold the control register. It sends a bit mask and a one-cycle strobe to the register's owner, which applies the clear in its usual order: the enable bit is handled first when it is falling.

The third function is a per-channel interrupt status register. Each channel raises a one-cycle event strobe. The event sets that channel's status bit, and the bit stays set until software clears it. Software clears bits by writing a value that is ANDed into the register. If a channel event and a status write arrive in the same cycle, the event takes priority.

Top module: `tmr_guard_regs`

## Requirements
- R1: A write to offset 0x38 whose data bits [8:1] equal 0xAE sets the unlock flag at the next clock edge.
- R2: A write to offset 0x38 whose data bits [8:1] equal 0xEA clears the unlock flag at the next clock edge.
- R3: Any other value in bits [8:1] of a write to offset 0x38 leaves the unlock flag unchanged. Data bit 0 and bits above 8 have no effect on the flag.
- R4: Reads are combinational from `bus_addr`. Offset 0x38 returns the unlock flag in bit 0 with every other bit zero. Offset 0x34 returns the status register in bits [NCH-1:0] with the upper bits zero. Offset 0x3C reads as zero.
- R5: While unlocked, a write to offset 0x3C drives `clr_stb` high for exactly the following cycle. In that cycle `clr_mask` equals the written data ANDed with `ctrl_word`.
- R6: While locked, a write to offset 0x3C is ignored: `clr_stb` stays low and `clr_mask` stays zero. Both are also low and zero in every cycle without a granted clear.
- R7: A high bit of `chan_evt` sets the matching status bit at the next edge. Status bits hold their value when no event and no status write occur.
- R8: A write to offset 0x34 with no event present leaves the status register equal to its old value ANDed with the written bits [NCH-1:0].
- R9: When a status write and channel events occur in the same cycle, the new status is (old AND written data) OR events, so the event wins.
- R10: A synchronous active-high reset clears the unlock flag and the status register and holds `clr_stb` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | ADDR_W | Byte offset for both reads and writes |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data for `bus_addr` |
| ctrl_word | input | DATA_W | Current value of the timer control register |
| chan_evt | input | NCH | One-cycle interrupt event strobes, one per channel |
| clr_mask | output | DATA_W | Control bits to be cleared, valid with the strobe |
| clr_stb | output | 1 | One-cycle strobe for a granted clear |
| irq_status | output | NCH | Sticky per-channel interrupt status |

## Verification
The hardest case to reach from the ports is the same-cycle collision between a status AND-write and channel events. A bench that only ever writes and then waits never produces that collision. The stimulus therefore first loads a known status value, then drives the write and a chosen event pattern on the same falling edge. The bench repeats this across a sweep of event patterns. The key decoder is covered by sweeping all 256 command bytes from both the locked and the unlocked state, with unrelated data bits toggled. The clear port is covered by alternating the lock state across a set of control words and masks.

// File: rtl/tmr_guard_pkg.sv
package tmr_guard_pkg;

    localparam logic [7:0] OFS_STATUS = 8'h34;
    localparam logic [7:0] OFS_KEY    = 8'h38;
    localparam logic [7:0] OFS_CLEAR  = 8'h3C;

    localparam logic [7:0] KEY_OPEN   = 8'hAE;
    localparam logic [7:0] KEY_SHUT   = 8'hEA;
    localparam int         KEY_LSB    = 1;
    localparam int         KEY_W      = 8;

    typedef enum logic [1:0] {
        KCMD_NONE = 2'd0,
        KCMD_OPEN = 2'd1,
        KCMD_SHUT = 2'd2
    } key_cmd_t;

    typedef struct packed {
        logic key;
        logic clr;
        logic sts;
    } wr_sel_t;

    function automatic key_cmd_t classify_key(input logic [KEY_W-1:0] k);
        if (k == KEY_OPEN)      return KCMD_OPEN;
        else if (k == KEY_SHUT) return KCMD_SHUT;
        else                    return KCMD_NONE;
    endfunction

endpackage

// File: rtl/tg_key_lock.sv
module tg_key_lock
    import tmr_guard_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_key,
    input  logic [DATA_W-1:0] wdata,
    output logic              unlocked
);

    key_cmd_t cmd;

    always_comb begin
        cmd = wr_key ? classify_key(wdata[KEY_LSB +: KEY_W]) : KCMD_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            unlocked <= 1'b0;
        end else begin
            unique case (cmd)
                KCMD_OPEN: unlocked <= 1'b1;
                KCMD_SHUT: unlocked <= 1'b0;
                default:   unlocked <= unlocked;
            endcase
        end
    end

    // R1
    key_open_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_key && wdata[KEY_LSB +: KEY_W] == 8'hAE) |=> unlocked);

    // R2
    key_shut_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_key && wdata[KEY_LSB +: KEY_W] == 8'hEA) |=> !unlocked);

    // R3
    key_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!wr_key || (wdata[KEY_LSB +: KEY_W] != 8'hAE && wdata[KEY_LSB +: KEY_W] != 8'hEA))
        |=> $stable(unlocked));

endmodule

// File: rtl/tg_clr_gate.sv
module tg_clr_gate #(
    parameter int CTRL_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_clr,
    input  logic              unlocked,
    input  logic [CTRL_W-1:0] wdata,
    input  logic [CTRL_W-1:0] ctrl_word,
    output logic [CTRL_W-1:0] clr_mask,
    output logic              clr_stb
);

    logic grant;

    always_comb begin
        grant = wr_clr && unlocked;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            clr_stb  <= 1'b0;
            clr_mask <= '0;
        end else begin
            clr_stb  <= grant;
            clr_mask <= grant ? (wdata & ctrl_word) : '0;
        end
    end

    // R5
    clr_grant_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_clr && unlocked) |=> (clr_stb && clr_mask == $past(wdata & ctrl_word)));

    // R6
    clr_block_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_clr && unlocked) |=> (!clr_stb && clr_mask == '0));

endmodule

// File: rtl/tg_sticky_sts.sv
module tg_sticky_sts #(
    parameter int NCH = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           wr_sts,
    input  logic [NCH-1:0] wdata,
    input  logic [NCH-1:0] events,
    output logic [NCH-1:0] status
);

    genvar g;
    generate
        for (g = 0; g < NCH; g++) begin : g_bit
            always_ff @(posedge clk) begin
                if (rst)
                    status[g] <= 1'b0;
                else if (events[g])
                    status[g] <= 1'b1;
                else if (wr_sts)
                    status[g] <= status[g] & wdata[g];
            end
        end
    endgenerate

    // R7
    sts_set_chk: assert property (@(posedge clk) disable iff (rst)
        (|events) |=> ((status & $past(events)) == $past(events)));

    // R7
    sts_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!wr_sts && events == '0) |=> $stable(status));

    // R8
    sts_and_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_sts && events == '0) |=> (status == $past(status & wdata)));

endmodule

// File: rtl/tmr_guard_regs.sv
module tmr_guard_regs
    import tmr_guard_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int NCH    = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] ctrl_word,
    input  logic [NCH-1:0]    chan_evt,
    output logic [DATA_W-1:0] clr_mask,
    output logic              clr_stb,
    output logic [NCH-1:0]    irq_status
);

    localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(OFS_STATUS);
    localparam logic [ADDR_W-1:0] A_KEY = ADDR_W'(OFS_KEY);
    localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(OFS_CLEAR);

    wr_sel_t sel;
    logic    unlocked;

    always_comb begin
        sel.key = bus_wr && (bus_addr == A_KEY);
        sel.clr = bus_wr && (bus_addr == A_CLR);
        sel.sts = bus_wr && (bus_addr == A_STS);
    end

    tg_key_lock #(.DATA_W(DATA_W)) u_lock (
        .clk      (clk),
        .rst      (rst),
        .wr_key   (sel.key),
        .wdata    (bus_wdata),
        .unlocked (unlocked)
    );

    tg_clr_gate #(.CTRL_W(DATA_W)) u_clr (
        .clk       (clk),
        .rst       (rst),
        .wr_clr    (sel.clr),
        .unlocked  (unlocked),
        .wdata     (bus_wdata),
        .ctrl_word (ctrl_word),
        .clr_mask  (clr_mask),
        .clr_stb   (clr_stb)
    );

    tg_sticky_sts #(.NCH(NCH)) u_sts (
        .clk    (clk),
        .rst    (rst),
        .wr_sts (sel.sts),
        .wdata  (bus_wdata[NCH-1:0]),
        .events (chan_evt),
        .status (irq_status)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_KEY)
            bus_rdata[0] = unlocked;
        else if (bus_addr == A_STS)
            bus_rdata[NCH-1:0] = irq_status;
    end

    // R10
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (irq_status == '0 && !unlocked && !clr_stb));

endmodule

// File: tb/tmr_guard_regs_bench.sv
module tmr_guard_regs_bench;

    localparam int AW = 8;
    localparam int DW = 32;
    localparam int NC = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic          bus_wr;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;
    logic [DW-1:0] bus_rdata;
    logic [DW-1:0] ctrl_word;
    logic [NC-1:0] chan_evt;
    logic [DW-1:0] clr_mask;
    logic          clr_stb;
    logic [NC-1:0] irq_status;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    tmr_guard_regs #(.ADDR_W(AW), .DATA_W(DW), .NCH(NC)) u_tmr_guard_regs (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ctrl_word(ctrl_word),
        .chan_evt(chan_evt), .clr_mask(clr_mask), .clr_stb(clr_stb),
        .irq_status(irq_status)
    );

    task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input logic [NC-1:0] ev);
        bus_wr = wr; bus_addr = a; bus_wdata = d; chan_evt = ev;
        @(negedge clk);
        bus_wr = 1'b0; chan_evt = '0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic finish_up;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        logic [DW-1:0] r;
        logic [DW-1:0] dv;
        logic          exp_u;
        logic [NC-1:0] exp_s;
        rst = 1'b1; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        ctrl_word = '0; chan_evt = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10 reset state
        rd(8'h38, r); chk(r == 32'd0, "R10 unlock after reset", r, 32'd0);
        rd(8'h34, r); chk(r == 32'd0, "R10 status after reset", r, 32'd0);
        chk(clr_stb == 1'b0, "R10 strobe after reset", {31'd0, clr_stb}, 32'd0);
        // R4 clear offset reads zero
        rd(8'h3C, r); chk(r == 32'd0, "R4 clear offset read", r, 32'd0);

        // R1 R2 R3 key sweep from both states, with noise outside [8:1]
        for (int st = 0; st < 2; st++) begin
            for (int k = 0; k < 256; k++) begin
                cyc(1'b1, 8'h38, (st != 0) ? 32'h15C : 32'h1D4, '0);
                dv = ({24'd0, 8'(k)} << 1) | ((k % 2 != 0) ? 32'hFFFF_FE01 : 32'd0);
                cyc(1'b1, 8'h38, dv, '0);
                exp_u = (k == 8'hAE) ? 1'b1 : (k == 8'hEA) ? 1'b0 : (st != 0);
                rd(8'h38, r);
                chk(r == {31'd0, exp_u},
                    (k == 8'hAE) ? "R1 open key" : (k == 8'hEA) ? "R2 shut key" : "R3 other key / R4",
                    r, {31'd0, exp_u});
            end
        end

        // R5 R6 clear port
        for (int i = 0; i < 64; i++) begin
            logic [DW-1:0] cw;
            logic [DW-1:0] m;
            bit            open;
            cw = 32'h9E37_79B9 * (i + 1);
            m  = {cw[12:0], cw[31:13]} ^ (32'h0F0F_0F0F << (i % 8));
            open = (i % 2) == 0;
            cyc(1'b1, 8'h38, open ? 32'h15C : 32'h1D4, '0);
            ctrl_word = cw;
            cyc(1'b1, 8'h3C, m, '0);
            if (open) begin
                chk(clr_stb == 1'b1, "R5 strobe", {31'd0, clr_stb}, 32'd1);
                chk(clr_mask == (m & cw), "R5 mask", clr_mask, m & cw);
            end else begin
                chk(clr_stb == 1'b0, "R6 locked strobe", {31'd0, clr_stb}, 32'd0);
                chk(clr_mask == 32'd0, "R6 locked mask", clr_mask, 32'd0);
            end
            cyc(1'b0, 8'h00, 32'd0, '0);
            chk(clr_stb == 1'b0, "R5 single-cycle strobe", {31'd0, clr_stb}, 32'd0);
            chk(clr_mask == 32'd0, "R6 idle mask", clr_mask, 32'd0);
        end

        // R7 R8 R9 status sweep
        for (int e = 0; e < 256; e++) begin
            logic [NC-1:0] ev;
            logic [NC-1:0] w;
            logic [NC-1:0] e2;
            ev = 8'(e);
            cyc(1'b1, 8'h34, 32'd0, '0);
            cyc(1'b0, 8'h00, 32'd0, ev);
            cyc(1'b0, 8'h00, 32'd0, '0);
            rd(8'h34, r);
            chk(r == {24'd0, ev}, "R7 event sets and holds / R4", r, {24'd0, ev});
            w = ev ^ 8'h5A ^ 8'(e * 7);
            cyc(1'b1, 8'h34, {24'hFFFFFF, w}, '0);
            exp_s = ev & w;
            rd(8'h34, r);
            chk(r == {24'd0, exp_s}, "R8 AND write", r, {24'd0, exp_s});
            e2 = 8'(e * 37 + 3);
            w  = 8'(e * 13);
            cyc(1'b1, 8'h34, {24'd0, w}, e2);
            exp_s = (exp_s & w) | e2;
            rd(8'h34, r);
            chk(r == {24'd0, exp_s}, "R9 event beats write", r, {24'd0, exp_s});
        end

        // R10 mid-run reset
        cyc(1'b1, 8'h38, 32'h15C, 8'hC3);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        rd(8'h38, r); chk(r == 32'd0, "R10 unlock cleared", r, 32'd0);
        rd(8'h34, r); chk(r == 32'd0, "R10 status cleared", r, 32'd0);
        finish_up();
    end

endmodule